// File: doc/BRIEF.md
# Packetizing Slave-FIFO Endpoint Buffer

This block is a single endpoint buffer that an external master fills through a clocked slave-FIFO port. On each rising edge of the interface clock the block samples an active-low chip select, a 3-bit FIFO address and four strobes: write, read, output enable and packet end. A write is taken only when the chip select is low and the address matches the endpoint's own address. Written bytes collect into a pending packet. That packet is committed as a whole, either when it reaches the programmed packet length or when the master raises the packet-end strobe early.

The drain side sees only committed packets. Its data is presented together with a last-byte marker and a zero-length-packet marker, and a read strobe consumes either one byte or one empty packet. A set of output flags reports status. Each flag picks its source through a 4-bit select code, and all flags share one coding. Flag polarity and strobe polarity can each be set by the master.

The data bus is split into a data output and a pad enable, so the high-impedance state is formed at the pad ring.

Top module: `pkt_slave_ep`

## Requirements
- R1: After reset no packet is committed, the empty source is active, the full and pending sources are inactive, and the pad enable is low.
- R2: A strobe has effect only in a cycle where chip select is low and the FIFO address equals the endpoint address. A write with chip select high or with another address leaves the pending count unchanged.
- R3: A write that makes the pending count reach the effective length commits the packet and clears the count. The effective length is the programmed length, or the maximum packet size when the programmed value is 0 or larger than that maximum.
- R4: A packet-end strobe commits the pending bytes as a short packet. If a write is accepted in the same cycle, that byte is included in the packet.
- R5: A packet-end strobe with no pending bytes commits a zero-length packet. While such a packet is at the head, the zero-length marker is high, and one read strobe removes the packet without consuming a byte.
- R6: Full is active when the byte store holds DEPTH bytes or the packet queue holds QDEPTH packets. Writes are ignored while full is active. A packet-end strobe is ignored while the packet queue is full.
- R7: A read strobe is ignored while no committed packet is available. Bytes that are pending but not yet committed cannot be read.
- R8: The pad enable is high only while output enable is active in a selected cycle. While the pad enable is low, the data output reads zero; otherwise the data output presents the head byte of the oldest committed packet.
- R9: The last-byte marker is high exactly while the presented byte is the final byte of a non-empty head packet.
- R10: The flag select codes are 0 = no committed packet (empty), 1 = full, 2 = stored byte count at or above the programmed level, and 3 = uncommitted bytes pending. Any other code gives an inactive flag.
- R11: With flag polarity 1, an active flag drives 1. With flag polarity 0, every flag output is inverted.
- R12: With strobe polarity 0, a strobe is active when its pin is 0. With strobe polarity 1, a strobe is active when its pin is 1. This setting applies to the write, read, output-enable and packet-end strobes.
- R13: Bytes are read out in the order they were written, both within a packet and across packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; every strobe and data transfer is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| fifo_addr | input | 3 | FIFO address, compared against EP_ADDR |
| wr_stb | input | 1 | Write strobe (polarity per stb_pol) |
| rd_stb | input | 1 | Read strobe (polarity per stb_pol) |
| oe_stb | input | 1 | Output enable strobe (polarity per stb_pol) |
| pkt_end_stb | input | 1 | Packet-end strobe (polarity per stb_pol) |
| stb_pol | input | 1 | 1: strobes active high; 0: active low |
| flag_pol | input | 1 | 1: flags active high; 0: active low |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Head byte while pad enable is high, else zero |
| rd_data_oe | output | 1 | Pad enable for the data bus |
| rd_last | output | 1 | Presented byte ends its packet |
| rd_zlp | output | 1 | Head packet has zero length |
| cfg_pkt_len | input | $clog2(MAX_PKT+1) | Programmed packet length (0 selects MAX_PKT) |
| cfg_level | input | $clog2(DEPTH+1) | Threshold for the level flag source |
| flag_sel | input | 4*NFLAG | 4-bit select code per flag |
| flags | output | NFLAG | Flag outputs |

## Verification
Counter and pointer state changes on the rising edge that samples a strobe. Flags, markers, data and pad enable are decoded combinationally from that state or from the present inputs. As a result, the effect of a write, read or packet-end strobe is visible one cycle after it is applied, and output enable takes effect in the same cycle. The bench changes inputs 1 ns after a rising edge and checks results 1 ns after the next rising edge. Pad-enable and data values are checked 1 ns after the output-enable inputs are set, before the clock edge. Reset release is given three extra cycles for the two-stage synchronizer before the first check.

// File: rtl/pkt_slave_ep_pkg.sv
package pkt_slave_ep_pkg;

  typedef enum logic [3:0] {
    FSEL_EMPTY = 4'd0,
    FSEL_FULL  = 4'd1,
    FSEL_LEVEL = 4'd2,
    FSEL_PEND  = 4'd3
  } flag_sel_e;

  typedef struct packed {
    logic empty;
    logic full;
    logic level;
    logic pend;
  } ep_status_t;

endpackage

// File: rtl/pkt_byte_store.sv
module pkt_byte_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] stored
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp, wp_n, rp_n;
  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    wp_n  = wp + AW'(1);
    rp_n  = rp + AW'(1);
    cnt_n = wr_en ? cnt + CW'(1) : cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en)         wp  <= wp_n;
      if (rd_en)         rp  <= rp_n;
      if (wr_en ^ rd_en) cnt <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  assign rd_data = mem[rp];
  assign stored  = cnt;

endmodule

// File: rtl/pkt_len_queue.sv
module pkt_len_queue #(
  parameter int QDEPTH = 4,
  parameter int LENW   = 10,
  localparam int QAW   = $clog2(QDEPTH),
  localparam int QCW   = $clog2(QDEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [LENW-1:0] push_len,
  input  logic            pop,
  output logic [LENW-1:0] head_len,
  output logic [QCW-1:0]  count,
  output logic            q_full,
  output logic            q_empty
);

  localparam logic [QCW-1:0] QMAX = QCW'(QDEPTH);

  logic [LENW-1:0] lens [QDEPTH];
  logic [QAW-1:0]  wp, rp, wp_n, rp_n;
  logic [QCW-1:0]  cnt, cnt_n;

  always_comb begin
    wp_n  = wp + QAW'(1);
    rp_n  = rp + QAW'(1);
    cnt_n = push ? cnt + QCW'(1) : cnt - QCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push)        wp  <= wp_n;
      if (pop)         rp  <= rp_n;
      if (push ^ pop)  cnt <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) lens[wp] <= push_len;
  end

  assign head_len = lens[rp];
  assign count    = cnt;
  assign q_full   = (cnt == QMAX);
  assign q_empty  = (cnt == '0);

endmodule

// File: rtl/pkt_assembler.sv
module pkt_assembler #(
  parameter int MAX_PKT = 512,
  localparam int LENW   = $clog2(MAX_PKT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_fire,
  input  logic            pe_fire,
  input  logic [LENW-1:0] cfg_len,
  output logic            commit,
  output logic [LENW-1:0] commit_len,
  output logic [LENW-1:0] pend
);

  localparam logic [LENW-1:0] LMAX = LENW'(MAX_PKT);

  logic [LENW-1:0] eff_len, pend_inc, pend_n;
  logic            reach;

  always_comb begin
    eff_len    = (cfg_len == '0 || cfg_len > LMAX) ? LMAX : cfg_len;
    pend_inc   = pend + LENW'(wr_fire);
    reach      = wr_fire && (pend_inc >= eff_len);
    commit     = reach || pe_fire;
    commit_len = pend_inc;
    pend_n     = commit ? '0 : pend_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pend <= '0;
    else if (wr_fire || pe_fire) pend <= pend_n;
  end

endmodule

// File: rtl/pkt_flag_mux.sv
module pkt_flag_mux
  import pkt_slave_ep_pkg::*;
#(
  parameter int NFLAG = 2
) (
  input  ep_status_t         st,
  input  logic [4*NFLAG-1:0] sel,
  input  logic               pol,
  output logic [NFLAG-1:0]   flags
);

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic raw;
    always_comb begin
      case (flag_sel_e'(sel[4*g +: 4]))
        FSEL_EMPTY: raw = st.empty;
        FSEL_FULL:  raw = st.full;
        FSEL_LEVEL: raw = st.level;
        FSEL_PEND:  raw = st.pend;
        default:    raw = 1'b0;
      endcase
    end
    assign flags[g] = pol ? raw : ~raw;
  end

endmodule

// File: rtl/pkt_slave_ep.sv
module pkt_slave_ep
  import pkt_slave_ep_pkg::*;
#(
  parameter int         DW      = 8,
  parameter int         DEPTH   = 1024,
  parameter int         MAX_PKT = 512,
  parameter int         QDEPTH  = 4,
  parameter int         NFLAG   = 2,
  parameter logic [2:0] EP_ADDR = 3'd2,
  localparam int        LENW    = $clog2(MAX_PKT + 1),
  localparam int        CW      = $clog2(DEPTH + 1),
  localparam int        QCW     = $clog2(QDEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic [2:0]         fifo_addr,
  input  logic               wr_stb,
  input  logic               rd_stb,
  input  logic               oe_stb,
  input  logic               pkt_end_stb,
  input  logic               stb_pol,
  input  logic               flag_pol,
  input  logic [DW-1:0]      wr_data,
  output logic [DW-1:0]      rd_data,
  output logic               rd_data_oe,
  output logic               rd_last,
  output logic               rd_zlp,
  input  logic [LENW-1:0]    cfg_pkt_len,
  input  logic [CW-1:0]      cfg_level,
  input  logic [4*NFLAG-1:0] flag_sel,
  output logic [NFLAG-1:0]   flags
);

  localparam logic [CW-1:0] SMAX = CW'(DEPTH);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  // strobe decode
  logic sel_i, wr_req, rd_req, oe_req, pe_req;
  logic full_i, wr_fire, rd_fire, pe_fire, avail;
  logic head_zlp, last_i, byte_rd, q_pop, zlp_pop;
  logic commit;
  logic [LENW-1:0] commit_len, pend, head_len;
  logic [LENW-1:0] rd_off, rd_off_n;
  logic [CW-1:0]   stored;
  logic [QCW-1:0]  q_count;
  logic            q_full, q_empty;
  logic [DW-1:0]   head_byte;
  ep_status_t      st;

  always_comb begin
    sel_i   = !cs_n && (fifo_addr == EP_ADDR);
    wr_req  = sel_i && (stb_pol ? wr_stb      : ~wr_stb);
    rd_req  = sel_i && (stb_pol ? rd_stb      : ~rd_stb);
    oe_req  = sel_i && (stb_pol ? oe_stb      : ~oe_stb);
    pe_req  = sel_i && (stb_pol ? pkt_end_stb : ~pkt_end_stb);

    full_i   = (stored == SMAX) || q_full;
    avail    = !q_empty;
    wr_fire  = wr_req && !full_i;
    pe_fire  = pe_req && !q_full;
    rd_fire  = rd_req && avail;

    head_zlp = avail && (head_len == '0);
    last_i   = avail && !head_zlp && (LENW'(rd_off + LENW'(1)) == head_len);
    byte_rd  = rd_fire && !head_zlp;
    q_pop    = rd_fire && (head_zlp || last_i);
    zlp_pop  = rd_fire && head_zlp;

    if (q_pop)        rd_off_n = '0;
    else              rd_off_n = rd_off + LENW'(1);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     rd_off <= '0;
    else if (rd_fire) rd_off <= rd_off_n;
  end

  pkt_assembler #(.MAX_PKT(MAX_PKT)) u_asm (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .wr_fire    (wr_fire),
    .pe_fire    (pe_fire),
    .cfg_len    (cfg_pkt_len),
    .commit     (commit),
    .commit_len (commit_len),
    .pend       (pend)
  );

  pkt_byte_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_en   (wr_fire),
    .wr_data (wr_data),
    .rd_en   (byte_rd),
    .rd_data (head_byte),
    .stored  (stored)
  );

  pkt_len_queue #(.QDEPTH(QDEPTH), .LENW(LENW)) u_q (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .push     (commit),
    .push_len (commit_len),
    .pop      (q_pop),
    .head_len (head_len),
    .count    (q_count),
    .q_full   (q_full),
    .q_empty  (q_empty)
  );

  always_comb begin
    st.empty = !avail;
    st.full  = full_i;
    st.level = (stored >= cfg_level);
    st.pend  = (pend != '0);
  end

  pkt_flag_mux #(.NFLAG(NFLAG)) u_flags (
    .st    (st),
    .sel   (flag_sel),
    .pol   (flag_pol),
    .flags (flags)
  );

  assign rd_data_oe = oe_req;
  assign rd_data    = oe_req ? head_byte : '0;
  assign rd_last    = last_i;
  assign rd_zlp     = head_zlp;

endmodule

// File: rtl/pkt_slave_ep_chk.sv
module pkt_slave_ep_chk #(
  parameter int  DEPTH   = 1024,
  parameter int  MAX_PKT = 512,
  parameter int  QDEPTH  = 4,
  localparam int LENW    = $clog2(MAX_PKT + 1),
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int QCW     = $clog2(QDEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            full_i,
  input logic            wr_req,
  input logic            wr_fire,
  input logic            rd_req,
  input logic            rd_fire,
  input logic            avail,
  input logic            pe_fire,
  input logic            commit,
  input logic            zlp_pop,
  input logic [LENW-1:0] pend,
  input logic [CW-1:0]   stored,
  input logic [QCW-1:0]  q_count
);

  p_no_write_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full_i && wr_req && !rd_fire) |=> $stable(stored));

  p_stored_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stored <= CW'(DEPTH));

  p_no_read_when_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!avail && rd_req && !wr_fire) |=> $stable(stored));

  p_pend_below_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend < LENW'(MAX_PKT));

  p_pktend_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pe_fire |=> (pend == '0));

  p_zlp_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (zlp_pop && !commit) |=> (QCW'(q_count + QCW'(1)) == $past(q_count)));

endmodule

bind pkt_slave_ep pkt_slave_ep_chk #(
  .DEPTH   (DEPTH),
  .MAX_PKT (MAX_PKT),
  .QDEPTH  (QDEPTH)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_i_n),
  .full_i  (full_i),
  .wr_req  (wr_req),
  .wr_fire (wr_fire),
  .rd_req  (rd_req),
  .rd_fire (rd_fire),
  .avail   (avail),
  .pe_fire (pe_fire),
  .commit  (commit),
  .zlp_pop (zlp_pop),
  .pend    (pend),
  .stored  (stored),
  .q_count (q_count)
);

// File: tb/pkt_slave_ep_tb.sv
`timescale 1ns/1ps
module pkt_slave_ep_tb;

  localparam int         DW = 8;
  localparam logic [2:0] EP = 3'd2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n;
  logic [2:0] fifo_addr;
  logic       wr_stb, rd_stb, oe_stb, pe_stb;
  logic       stb_pol, flag_pol;
  logic [7:0] wr_data, rd_data;
  logic       rd_data_oe, rd_last, rd_zlp;
  logic [3:0] cfg_pkt_len;
  logic [4:0] cfg_level;
  logic [7:0] flag_sel;
  logic [1:0] flags;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  pkt_slave_ep #(
    .DW(DW), .DEPTH(16), .MAX_PKT(8), .QDEPTH(4), .NFLAG(2), .EP_ADDR(EP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fifo_addr(fifo_addr),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .oe_stb(oe_stb), .pkt_end_stb(pe_stb),
    .stb_pol(stb_pol), .flag_pol(flag_pol), .wr_data(wr_data),
    .rd_data(rd_data), .rd_data_oe(rd_data_oe), .rd_last(rd_last), .rd_zlp(rd_zlp),
    .cfg_pkt_len(cfg_pkt_len), .cfg_level(cfg_level), .flag_sel(flag_sel), .flags(flags)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic lv(input logic a);
    return stb_pol ? a : ~a;
  endfunction

  task automatic drive(input logic w, input logic r, input logic o, input logic p,
                       input logic [7:0] d, input logic en = 1'b1, input logic [2:0] ad = EP);
    cs_n      = ~en;
    fifo_addr = ad;
    wr_stb    = lv(w);
    rd_stb    = lv(r);
    oe_stb    = lv(o);
    pe_stb    = lv(p);
    wr_data   = d;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic step(input logic w, input logic r, input logic p, input logic [7:0] d);
    drive(w, r, 1'b0, p, d);
    tick();
    idle();
  endtask

  task automatic read_chk(input string req, input int exp_d, input int exp_last);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    #1;
    chk("R8", "pad enable on read", int'(rd_data_oe), 1);
    chk(req, "read data", int'(rd_data), exp_d);
    chk("R9", "last-byte marker", int'(rd_last), exp_last);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
    tick();
    idle();
  endtask

  // flags[0] shows empty, flags[1] shows sel1 (polarity 1)
  task automatic t_reset();
    chk("R1", "empty after reset", int'(flags[0]), 1);
    chk("R1", "full after reset", int'(flags[1]), 0);
    flag_sel[7:4] = 4'd3;
    #1;
    chk("R1", "pending after reset", int'(flags[1]), 0);
    chk("R1", "pad enable after reset", int'(rd_data_oe), 0);
    chk("R1", "zlp marker after reset", int'(rd_zlp), 0);
  endtask

  task automatic t_select();
    cfg_pkt_len = 4'd8;
    flag_sel[7:4] = 4'd3;
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h55, 1'b0, EP); tick(); idle();
    chk("R2", "write with chip select high", int'(flags[1]), 0);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h55, 1'b1, 3'd3); tick(); idle();
    chk("R2", "write to other address", int'(flags[1]), 0);
    step(1'b1, 1'b0, 1'b0, 8'h55);
    chk("R2", "selected write pending", int'(flags[1]), 1);
    step(1'b0, 1'b0, 1'b1, 8'h00);
    chk("R4", "packet end commits", int'(flags[0]), 0);
    read_chk("R2", 8'h55, 1);
    chk("R2", "drained", int'(flags[0]), 1);
  endtask

  task automatic t_auto();
    flag_sel[7:4] = 4'd3;
    cfg_pkt_len = 4'd4;
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b0, 1'b0, 8'(8'h10 + i));
      if (i == 2) chk("R3", "no commit before length", int'(flags[0]), 1);
    end
    chk("R3", "commit at length", int'(flags[0]), 0);
    chk("R3", "count cleared at commit", int'(flags[1]), 0);
    for (int i = 0; i < 4; i++) read_chk("R3", 8'h10 + i, (i == 3) ? 1 : 0);
    cfg_pkt_len = 4'd0;
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 1'b0, 1'b0, 8'(8'h20 + i));
      if (i == 6) chk("R3", "length 0 no early commit", int'(flags[0]), 1);
    end
    chk("R3", "length 0 commits at max", int'(flags[0]), 0);
    cfg_pkt_len = 4'd12;
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0, 8'(8'h30 + i));
    chk("R3", "oversize length commits at max", int'(flags[1]), 0);
    for (int i = 0; i < 16; i++)
      read_chk("R13", (i < 8) ? (8'h20 + i) : (8'h30 + i - 8), (i == 7 || i == 15) ? 1 : 0);
    chk("R13", "drained", int'(flags[0]), 1);
  endtask

  task automatic t_short();
    flag_sel[7:4] = 4'd3;
    cfg_pkt_len = 4'd8;
    step(1'b1, 1'b0, 1'b0, 8'h41);
    step(1'b1, 1'b0, 1'b0, 8'h42);
    step(1'b1, 1'b0, 1'b1, 8'h43);
    chk("R4", "short packet committed", int'(flags[0]), 0);
    chk("R4", "nothing left pending", int'(flags[1]), 0);
    read_chk("R4", 8'h41, 0);
    read_chk("R4", 8'h42, 0);
    read_chk("R4", 8'h43, 1);
    chk("R4", "drained", int'(flags[0]), 1);
  endtask

  task automatic t_zlp();
    step(1'b0, 1'b0, 1'b1, 8'h00);
    chk("R5", "zero-length commit", int'(flags[0]), 0);
    chk("R5", "zlp marker", int'(rd_zlp), 1);
    step(1'b0, 1'b1, 1'b0, 8'h00);
    chk("R5", "zlp removed", int'(flags[0]), 1);
    chk("R5", "zlp marker cleared", int'(rd_zlp), 0);
    step(1'b1, 1'b0, 1'b0, 8'h51);
    step(1'b1, 1'b0, 1'b1, 8'h52);
    step(1'b0, 1'b0, 1'b1, 8'h00);
    chk("R5", "data head is not zlp", int'(rd_zlp), 0);
    read_chk("R5", 8'h51, 0);
    read_chk("R5", 8'h52, 1);
    chk("R5", "zlp after data packet", int'(rd_zlp), 1);
    step(1'b0, 1'b1, 1'b0, 8'h00);
    chk("R5", "drained", int'(flags[0]), 1);
  endtask

  task automatic t_full();
    flag_sel[7:4] = 4'd1;
    cfg_pkt_len = 4'd4;
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 1'b0, 1'b0, 8'(8'h60 + i));
      if (i == 14) chk("R6", "not full at 15 bytes", int'(flags[1]), 0);
    end
    chk("R6", "full at 16 bytes", int'(flags[1]), 1);
    step(1'b1, 1'b0, 1'b0, 8'h99);
    for (int i = 0; i < 16; i++) read_chk("R6", 8'h60 + i, (i % 4 == 3) ? 1 : 0);
    chk("R6", "ignored write left nothing", int'(flags[0]), 1);
    flag_sel[7:4] = 4'd3;
    #1;
    chk("R6", "ignored write not pending", int'(flags[1]), 0);
    flag_sel[7:4] = 4'd1;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1, 8'h00);
    chk("R6", "full on packet queue", int'(flags[1]), 1);
    step(1'b1, 1'b0, 1'b0, 8'h77);
    step(1'b0, 1'b0, 1'b1, 8'h00);
    for (int i = 0; i < 4; i++) begin
      chk("R6", "queued zlp", int'(rd_zlp), 1);
      step(1'b0, 1'b1, 1'b0, 8'h00);
    end
    chk("R6", "extra packet end ignored", int'(flags[0]), 1);
    flag_sel[7:4] = 4'd3;
    #1;
    chk("R6", "write while queue full ignored", int'(flags[1]), 0);
  endtask

  task automatic t_empty_read();
    cfg_pkt_len = 4'd8;
    step(1'b1, 1'b0, 1'b0, 8'h81);
    step(1'b1, 1'b0, 1'b0, 8'h82);
    step(1'b0, 1'b1, 1'b0, 8'h00);
    step(1'b0, 1'b0, 1'b1, 8'h00);
    read_chk("R7", 8'h81, 0);
    read_chk("R7", 8'h82, 1);
    chk("R7", "drained", int'(flags[0]), 1);
  endtask

  task automatic t_oe();
    step(1'b1, 1'b0, 1'b1, 8'hA5);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, EP);
    #1;
    chk("R8", "pad off without chip select", int'(rd_data_oe), 0);
    chk("R8", "data zero when pad off", int'(rd_data), 0);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 3'd5);
    #1;
    chk("R8", "pad off for other address", int'(rd_data_oe), 0);
    idle();
    read_chk("R8", 8'hA5, 1);
  endtask

  task automatic t_flags();
    cfg_pkt_len = 4'd8;
    cfg_level = 5'd3;
    flag_sel = {4'hF, 4'd2};
    step(1'b1, 1'b0, 1'b0, 8'h91);
    step(1'b1, 1'b0, 1'b0, 8'h92);
    chk("R10", "level below threshold", int'(flags[0]), 0);
    step(1'b1, 1'b0, 1'b0, 8'h93);
    chk("R10", "level at threshold", int'(flags[0]), 1);
    chk("R10", "unused code inactive", int'(flags[1]), 0);
    flag_pol = 1'b0;
    #1;
    chk("R11", "inverted level", int'(flags[0]), 0);
    chk("R11", "inverted unused code", int'(flags[1]), 1);
    flag_pol = 1'b1;
    flag_sel = {4'd3, 4'd0};
    step(1'b0, 1'b0, 1'b1, 8'h00);
    read_chk("R10", 8'h91, 0);
    read_chk("R10", 8'h92, 0);
    read_chk("R10", 8'h93, 1);
    flag_pol = 1'b0;
    #1;
    chk("R11", "inverted empty", int'(flags[0]), 0);
    flag_pol = 1'b1;
  endtask

  task automatic t_stb_pol();
    flag_sel = {4'd3, 4'd0};
    stb_pol = 1'b1;
    idle();
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'hEE);
    tick();
    idle();
    chk("R12", "low pins inactive when high polarity", int'(flags[1]), 0);
    step(1'b1, 1'b0, 1'b1, 8'hC1);
    chk("R12", "active-high write and packet end", int'(flags[0]), 0);
    read_chk("R12", 8'hC1, 1);
    stb_pol = 1'b0;
    idle();
    chk("R12", "drained", int'(flags[0]), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog all requirements actual=timeout expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    stb_pol = 1'b0;
    flag_pol = 1'b1;
    cfg_pkt_len = 4'd8;
    cfg_level = 5'd16;
    flag_sel = {4'd1, 4'd0};
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_select();
    t_auto();
    t_short();
    t_zlp();
    t_full();
    t_empty_read();
    t_oe();
    t_flags();
    t_stb_pol();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule